// File: doc/BRIEF.md
# Nine-Bit Multidrop Bus Poller

This block is the master end of a half-duplex serial bus on which every character has nine payload bits. The top payload bit tells the two character kinds apart. A one marks an address character, and a zero marks a data character. The block calls the stations one at a time by sending an address character, from station 1 up to station `NUM_ADDR`. It then returns to station 1. Station 0 is never called. While a call character is on the wire, the block raises a driver-enable output for the bus transceiver. It drops that output before it starts to listen.

After each call the block opens a reply window of `WIN_CYC` clock cycles. Each data character that arrives inside the window goes out as a one-cycle strobe. The strobe carries the eight data bits and the number of the station being polled. A character that arrives with its top bit set is discarded and reported on an error strobe. The window is held open while a character is being received, and it starts again after each stop bit. A reply of several characters therefore ends only when the line has been quiet for a full window. The receiver takes its samples at mid-bit, using a 16x oversample tick.

Top module: `mdb_poll`

## Requirements
- R1: A call character is a low start bit, then nine payload bits with the least significant bit first, then a high stop bit, each lasting `BIT_CYC` cycles. Payload bit 8 is 1, bits 4:0 hold the station number, and bits 7:5 are 0.
- R2: Stations are called in ascending order from 1 to `NUM_ADDR`. After `NUM_ADDR` the sequence wraps to 1, and 0 is never called.
- R3: `drv_en` is high from the first cycle of the start bit through the last cycle of the stop bit, which is 11*`BIT_CYC` cycles. It is low during the reply window.
- R4: If no character arrives, the next call's start bit begins between `WIN_CYC` and `WIN_CYC`+3 cycles after `drv_en` falls.
- R5: A character received inside the window with payload bit 8 equal to 0 gives one `rx_valid` pulse. On that pulse `rx_data` holds payload bits 7:0 and `rx_addr` holds the polled station.
- R6: A character received inside the window with payload bit 8 equal to 1 gives one `proto_err` pulse and no `rx_valid`.
- R7: The window does not expire while a character is in progress, and it restarts after each stop bit. A reply of several characters is delivered whole, and the next call follows the last stop bit after about `WIN_CYC` cycles.
- R8: A character that completes while the call is still being sent produces no `rx_valid` and no `proto_err`.
- R9: While reset is active and just after it, `txd` is high, `drv_en` is low, and `rx_valid` and `proto_err` are low. The first call after reset is to station 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| drv_en | output | 1 | Bus driver enable, high while a call character is sent |
| rx_valid | output | 1 | One-cycle strobe for a received data character |
| rx_data | output | 8 | Data bits of the received character |
| rx_addr | output | $clog2(NUM_ADDR+1) | Station polled when the character arrived |
| proto_err | output | 1 | One-cycle strobe for an address-flagged reply, which is discarded |

## Verification
Two events can fall in the same cycle: the window timer reaching its limit, and a character still being received. The bench provokes this by making every reply longer than the whole window. Each reply starts shortly after `drv_en` falls, so a timer that kept running would expire while the first character was still being received. The test passes only if every character of a two-character reply is delivered with the correct station tag, and the next call starts about one window after the last stop bit. A second overlap is a character that finishes on `rxd` a few cycles before the call character's stop bit ends. The bench judges it by the absence of any strobe for that poll.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
    typedef enum logic [1:0] {P_CALL, P_SEND, P_WIN} poll_st_e;
    typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_e;
endpackage

// File: rtl/mdb_tx.sv
module mdb_tx #(
    parameter int BIT_CYC = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [8:0] payload,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(BIT_CYC);

    typedef struct packed {
        logic          busy;
        logic [10:0]   sh;
        logic [CW-1:0] cnt;
        logic [3:0]    idx;
    } tx_t;

    tx_t r_d, r_q;
    logic bit_end;

    always_comb begin
        r_d     = r_q;
        bit_end = (r_q.cnt == CW'(BIT_CYC - 1));
        done    = r_q.busy && bit_end && (r_q.idx == 4'd10);
        if (!r_q.busy) begin
            if (start) begin
                r_d.busy = 1'b1;
                r_d.sh   = {1'b1, payload, 1'b0};
                r_d.cnt  = '0;
                r_d.idx  = '0;
            end
        end else if (bit_end) begin
            r_d.cnt = '0;
            if (r_q.idx == 4'd10) begin
                r_d.busy = 1'b0;
            end else begin
                r_d.sh  = {1'b1, r_q.sh[10:1]};
                r_d.idx = r_q.idx + 4'd1;
            end
        end else begin
            r_d.cnt = r_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{busy: 1'b0, sh: '1, cnt: '0, idx: '0};
        else        r_q <= r_d;
    end

    assign txd  = r_q.busy ? r_q.sh[0] : 1'b1;
    assign busy = r_q.busy;

    assert_no_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !r_q.busy) else $error("call started while transmitter busy");
endmodule

// File: rtl/mdb_rx.sv
module mdb_rx
    import mdb_pkg::*;
#(
    parameter int BIT_CYC = 256,
    parameter int OVS     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       busy,
    output logic       ch_valid,
    output logic [8:0] ch
);
    localparam int TICK = BIT_CYC / OVS;
    localparam int DW   = (TICK > 1) ? $clog2(TICK) : 1;
    localparam int OW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    typedef struct packed {
        logic          s1;
        logic          s2;
        rx_st_e        st;
        logic [DW-1:0] div;
        logic [OW-1:0] ovs;
        logic [3:0]    idx;
        logic [8:0]    sh;
        logic          valid;
    } rx_t;

    rx_t r_d, r_q;
    logic tick;

    always_comb begin
        r_d       = r_q;
        r_d.s1    = rxd;
        r_d.s2    = r_q.s1;
        r_d.valid = 1'b0;
        tick      = (r_q.div == DW'(TICK - 1));
        if (r_q.st != R_IDLE) r_d.div = tick ? '0 : r_q.div + DW'(1);
        unique case (r_q.st)
            R_IDLE: begin
                r_d.div = '0;
                r_d.ovs = '0;
                if (!r_q.s2) r_d.st = R_START;
            end
            R_START: if (tick) begin
                if (r_q.ovs == OW'(HALF - 1)) begin
                    r_d.ovs = '0;
                    r_d.idx = '0;
                    r_d.st  = r_q.s2 ? R_IDLE : R_DATA;
                end else r_d.ovs = r_q.ovs + OW'(1);
            end
            R_DATA: if (tick) begin
                if (r_q.ovs == OW'(OVS - 1)) begin
                    r_d.ovs = '0;
                    r_d.sh  = {r_q.s2, r_q.sh[8:1]};
                    if (r_q.idx == 4'd8) r_d.st = R_STOP;
                    else                 r_d.idx = r_q.idx + 4'd1;
                end else r_d.ovs = r_q.ovs + OW'(1);
            end
            R_STOP: if (tick) begin
                if (r_q.ovs == OW'(OVS - 1)) begin
                    r_d.valid = r_q.s2;
                    r_d.st    = R_IDLE;
                end else r_d.ovs = r_q.ovs + OW'(1);
            end
            default: r_d.st = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b1, s2: 1'b1, st: R_IDLE, div: '0, ovs: '0,
                             idx: '0, sh: '0, valid: 1'b0};
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != R_IDLE);
    assign ch_valid = r_q.valid;
    assign ch       = r_q.sh;

    assert_char_ends_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> (r_q.st == R_IDLE) && $past(r_q.st == R_STOP))
        else $error("character strobe outside stop phase");
endmodule

// File: rtl/mdb_poll.sv
module mdb_poll
    import mdb_pkg::*;
#(
    parameter int BIT_CYC  = 256,
    parameter int OVS      = 16,
    parameter int WIN_CYC  = 1600,
    parameter int NUM_ADDR = 31,
    localparam int AW      = $clog2(NUM_ADDR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    output logic          txd,
    output logic          drv_en,
    output logic          rx_valid,
    output logic [7:0]    rx_data,
    output logic [AW-1:0] rx_addr,
    output logic          proto_err
);
    localparam int WW = $clog2(WIN_CYC + 1);

    typedef struct packed {
        poll_st_e      st;
        logic [AW-1:0] addr;
        logic [WW-1:0] wcnt;
        logic          valid;
        logic [7:0]    data;
        logic [AW-1:0] tag;
        logic          err;
    } poll_t;

    poll_t p_d, p_q;
    logic       tx_start, tx_busy, tx_done;
    logic       rx_busy, ch_valid;
    logic [8:0] ch;
    logic [8:0] call_char;

    assign call_char = {1'b1, 8'(p_q.addr)};
    assign tx_start  = (p_q.st == P_CALL);

    mdb_tx #(.BIT_CYC(BIT_CYC)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .payload(call_char),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    mdb_rx #(.BIT_CYC(BIT_CYC), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .busy(rx_busy), .ch_valid(ch_valid), .ch(ch)
    );

    always_comb begin
        p_d       = p_q;
        p_d.valid = 1'b0;
        p_d.err   = 1'b0;
        unique case (p_q.st)
            P_CALL: p_d.st = P_SEND;
            P_SEND: if (tx_done) begin
                p_d.st   = P_WIN;
                p_d.wcnt = '0;
            end
            P_WIN: begin
                if (ch_valid) begin
                    p_d.wcnt = '0;
                    if (ch[8]) p_d.err = 1'b1;
                    else begin
                        p_d.valid = 1'b1;
                        p_d.data  = ch[7:0];
                        p_d.tag   = p_q.addr;
                    end
                end else if (rx_busy) begin
                    p_d.wcnt = '0;
                end else if (p_q.wcnt == WW'(WIN_CYC - 1)) begin
                    p_d.st   = P_CALL;
                    p_d.addr = (p_q.addr == AW'(NUM_ADDR)) ? AW'(1) : p_q.addr + AW'(1);
                end else begin
                    p_d.wcnt = p_q.wcnt + WW'(1);
                end
            end
            default: p_d.st = P_CALL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{st: P_CALL, addr: AW'(1), wcnt: '0, valid: 1'b0,
                             data: '0, tag: '0, err: 1'b0};
        else        p_q <= p_d;
    end

    assign drv_en    = tx_busy;
    assign rx_valid  = p_q.valid;
    assign rx_data   = p_q.data;
    assign rx_addr   = p_q.tag;
    assign proto_err = p_q.err;

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.addr != '0) && (p_q.addr <= AW'(NUM_ADDR))) else $error("station out of range");
    assert_drv_off_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.st == P_WIN) |-> !drv_en) else $error("driver on during reply window");
    assert_strobe_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || proto_err) |-> $past(p_q.st == P_WIN)) else $error("strobe outside window");
    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && proto_err)) else $error("data and error strobe together");
endmodule

// File: tb/mdb_poll_bench.sv
module mdb_poll_bench;
    localparam int BIT = 32;
    localparam int OVS = 16;
    localparam int WIN = 200;
    localparam int NA  = 31;
    localparam int NV  = 6;
    // entry: station[24:20], char count[19:18], first char[17:9], second char[8:0]
    localparam logic [24:0] VEC [0:NV-1] = '{
        {5'd2,  2'd1, 9'h0A5, 9'h000},
        {5'd3,  2'd2, 9'h03C, 9'h0FF},
        {5'd5,  2'd1, 9'h155, 9'h000},
        {5'd7,  2'd2, 9'h100, 9'h081},
        {5'd30, 2'd1, 9'h000, 9'h000},
        {5'd31, 2'd2, 9'h012, 9'h034}
    };

    logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
    logic txd, drv_en, rx_valid, proto_err;
    logic [7:0] rx_data;
    logic [4:0] rx_addr;
    int checks = 0, fails = 0, cyc = 0, pidx = 0;
    int cap_n [0:39];
    int err_n [0:39];
    logic [7:0] cap_d0 [0:39];
    logic [7:0] cap_d1 [0:39];
    logic [4:0] cap_a  [0:39];

    always #2 clk = ~clk;

    mdb_poll #(.BIT_CYC(BIT), .OVS(OVS), .WIN_CYC(WIN), .NUM_ADDR(NA)) u_mdb_poll (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .drv_en(drv_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_addr(rx_addr), .proto_err(proto_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 40; i++) begin
                cap_n[i] = 0; err_n[i] = 0; cap_d0[i] = '0; cap_d1[i] = '0; cap_a[i] = '0;
            end
        end else begin
            if (rx_valid) begin
                if (cap_n[pidx] == 0) cap_d0[pidx] = rx_data;
                else                  cap_d1[pidx] = rx_data;
                cap_a[pidx] = rx_addr;
                cap_n[pidx] = cap_n[pidx] + 1;
            end
            if (proto_err) err_n[pidx] = err_n[pidx] + 1;
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        fails = fails + 1;
        $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
        report();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [8:0] c);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            rxd = c[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    // samples the call character at mid-bit; returns with drv_en low
    task automatic read_call(input int exp_addr, input int t_rise, output int t_fall);
        logic [10:0] f;
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            f[i] = txd;
            if (i < 10) repeat (BIT) @(negedge clk);
        end
        chk(f[0] == 1'b0 && f[10] == 1'b1, "R1 framing", int'({f[10], f[0]}), 2);
        chk(f[9:1] == {4'b1000, 5'(exp_addr)}, "R1/R2 call payload", int'(f[9:1]),
            int'({4'b1000, 5'(exp_addr)}));
        while (drv_en) @(negedge clk);
        t_fall = cyc;
        chk(t_fall - t_rise == 11 * BIT, "R3 drv_en length", t_fall - t_rise, 11 * BIT);
    endtask

    initial begin
        int t_rise, t_fall, t_end, prev_fall, prev_end, prev_n, exp_addr;
        logic [24:0] prev_v;
        t_fall = 0; t_end = 0; prev_n = 0; prev_v = '0;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1 && drv_en == 1'b0, "R9 idle in reset", int'({txd, drv_en}), 2);
        chk(!rx_valid && !proto_err, "R9 strobes low in reset", int'({rx_valid, proto_err}), 0);
        rst_n = 1'b1;
        for (int p = 0; p < 33; p++) begin
            while (!drv_en) @(negedge clk);
            t_rise = cyc;
            if (p > 0) begin
                if (prev_n == 0)
                    chk(t_rise - prev_fall >= WIN && t_rise - prev_fall <= WIN + 3,
                        "R4 silent window", t_rise - prev_fall, WIN + 1);
                else begin
                    chk(t_rise - prev_end >= WIN - BIT && t_rise - prev_end <= WIN + BIT,
                        "R7 window after last stop", t_rise - prev_end, WIN);
                    chk(cap_n[p-1] == (prev_n - (prev_v[17] ? 1 : 0) - ((prev_n == 2 && prev_v[8]) ? 1 : 0)),
                        "R5/R7 data strobes", cap_n[p-1], prev_n);
                    chk(err_n[p-1] == (prev_v[17] ? 1 : 0) + ((prev_n == 2 && prev_v[8]) ? 1 : 0),
                        "R6 error strobes", err_n[p-1], int'(prev_v[17]));
                    if (cap_n[p-1] > 0) begin
                        logic [7:0] e0;
                        e0 = prev_v[17] ? prev_v[7:0] : prev_v[16:9];
                        chk(cap_d0[p-1] == e0, "R5 data", int'(cap_d0[p-1]), int'(e0));
                        chk(cap_a[p-1] == prev_v[24:20], "R5 station tag", int'(cap_a[p-1]),
                            int'(prev_v[24:20]));
                    end
                    if (cap_n[p-1] == 2)
                        chk(cap_d1[p-1] == prev_v[7:0], "R7 second char", int'(cap_d1[p-1]),
                            int'(prev_v[7:0]));
                end
            end
            pidx = p;
            exp_addr = (p % NA) + 1;
            if (p == 32) begin
                // R8: a character that completes while the call is still going out
                fork
                    read_call(exp_addr, t_rise, t_fall);
                    send_char(9'h066);
                join
            end else read_call(exp_addr, t_rise, t_fall);
            prev_fall = t_fall;
            prev_n = 0;
            for (int v = 0; v < NV; v++)
                if (p < NA && VEC[v][24:20] == 5'(exp_addr)) begin
                    prev_v = VEC[v];
                    prev_n = int'(VEC[v][19:18]);
                end
            if (prev_n > 0) begin
                repeat (20) @(negedge clk);
                send_char(prev_v[17:9]);
                t_end = cyc;
                repeat (BIT / 2) @(negedge clk);
                if (prev_n == 2) begin
                    send_char(prev_v[8:0]);
                    t_end = cyc;
                    repeat (BIT / 2) @(negedge clk);
                end
                prev_end = t_end;
            end
        end
        repeat (WIN + 20) @(negedge clk);
        chk(cap_n[32] == 0 && err_n[32] == 0, "R8 char during call ignored",
            cap_n[32] + err_n[32], 0);
        // directed: reset in mid run, first call goes to station 1
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(txd == 1'b1 && drv_en == 1'b0, "R9 idle after mid-run reset", int'({txd, drv_en}), 2);
        rst_n = 1'b1;
        while (!drv_en) @(negedge clk);
        t_rise = cyc;
        pidx = 35;
        read_call(1, t_rise, t_fall);
        report();
    end
endmodule